// File: doc/BRIEF.md
# Stack-Based Integer Datapath

This block is a 32-bit integer execution datapath whose operands live in a three-entry push-down stack of registers, named A (top), B and C, rather than in an addressable register file. A caller drives one command per cycle. A push places a data word on the stack. A pop removes the top word and returns it. The arithmetic commands take their inputs from the top two entries and leave their result on the top.

Add, subtract and both shifts complete in the cycle in which they are accepted. The shifts use a logarithmic barrel shifter, so every shift amount takes the same single cycle. Multiply is split into two partial-product steps and takes three cycles. While it runs, the block raises `busy` and drops every new command. Every completed command produces a one-cycle `done` pulse. The caller reads the new top of stack from `top_q`, and the value removed by the last pop from `pop_q`.

Top module: `estk_core`

## Requirements
- R1: While `rst_n` is low, and until the first command after it rises, A, B and C hold zero, `busy` and `done` are low, and `top_q` and `pop_q` read zero.
- R2: A push (op code 1) accepted at a clock edge updates all three entries in that edge. C takes the old B, B takes the old A, and A takes `cmd_data`.
- R3: A pop (op code 2) accepted at an edge loads the old A into `pop_q`, moves the old B into A and the old C into B. The contents of C are undefined afterwards.
- R4: Add (op code 3) writes (B + A) mod 2^32 into A and moves C into B. C is undefined afterwards.
- R5: Subtract (op code 4) writes (B - A) mod 2^32 into A and moves C into B. C is undefined afterwards.
- R6: Multiply (op code 5) writes the low 32 bits of B times A into A and moves C into B. If the command is accepted at edge k, `busy` is high after edges k and k+1, and the result and `done` appear after edge k+2, with `busy` low again.
- R7: Any command presented while `busy` is high is ignored and changes neither the stack nor `pop_q`.
- R8: Shift-left (op code 6) and shift-right (op code 7) write B shifted by the unsigned amount in A into A in a single cycle, filling with zeros, and move C into B. Any amount of 32 or more gives zero.
- R9: Op code 0 is a no-operation. It changes no entry and produces no `done` pulse.
- R10: `done` is high for exactly one cycle after each completed push, pop or arithmetic command. It is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (0 nop, 1 push, 2 pop, 3 add, 4 sub, 5 mul, 6 shl, 7 shr) |
| cmd_data | input | 32 | Word to push |
| top_q | output | 32 | Current contents of A |
| pop_q | output | 32 | Word removed by the most recent pop |
| busy | output | 1 | Multiply in progress; commands are ignored |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
The hardest case to reach is a command that arrives in the middle of a multiply. It must be provably dropped, even though the stack is about to be rewritten by the write-back. The bench reaches it by driving a push exactly one cycle after the multiply is accepted. It then checks that the top holds the product and that a later pop returns the entry that was below it, not the injected word. Undefined C entries are tracked as unknown in the reference model, so checks never depend on them. Reset zeros in B and C are brought out by popping three times straight after reset.

// File: rtl/estk_pkg.sv
package estk_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_MUL  = 3'd5,
    OP_SHL  = 3'd6,
    OP_SHR  = 3'd7
  } stk_op_e;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_LO   = 2'd1,
    MS_HI   = 2'd2
  } mul_st_e;

endpackage

// File: rtl/estk_regs.sv
module estk_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_en,
  input  logic         pop_en,
  input  logic         fold_en,
  input  logic [W-1:0] push_val,
  input  logic [W-1:0] fold_val,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] c_q
);

  logic [W-1:0] a_d, b_d, c_d;
  logic         stk_en;

  assign stk_en = push_en | pop_en | fold_en;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    c_d = c_q;
    if (push_en) begin
      c_d = b_q;
      b_d = a_q;
      a_d = push_val;
    end else if (pop_en) begin
      a_d = b_q;
      b_d = c_q;
    end else if (fold_en) begin
      a_d = fold_val;
      b_d = c_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (stk_en) begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
    end
  end

  // R2
  push_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> (a_q == $past(push_val)) && (b_q == $past(a_q)) && (c_q == $past(b_q)));

  // R3
  pop_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> (a_q == $past(b_q)) && (b_q == $past(c_q)));

  // R4
  fold_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold_en |=> (a_q == $past(fold_val)) && (b_q == $past(c_q)));

endmodule

// File: rtl/estk_shift.sv
module estk_shift #(
  parameter int W = 32
) (
  input  logic         go_left,
  input  logic [W-1:0] val,
  input  logic [W-1:0] amt,
  output logic [W-1:0] res
);

  localparam int SW = $clog2(W);

  logic [W-1:0] lstage [0:SW];
  logic [W-1:0] rstage [0:SW];
  logic         too_far;

  assign lstage[0] = val;
  assign rstage[0] = val;
  assign too_far   = |amt[W-1:SW];

  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign lstage[s+1] = amt[s] ? (lstage[s] << (1 << s)) : lstage[s];
    assign rstage[s+1] = amt[s] ? (rstage[s] >> (1 << s)) : rstage[s];
  end

  always_comb begin
    if (too_far)      res = '0;
    else if (go_left) res = lstage[SW];
    else              res = rstage[SW];
  end

endmodule

// File: rtl/estk_mul.sv
module estk_mul
  import estk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic         wb,
  output logic [W-1:0] result
);

  localparam int HALF = W / 2;

  mul_st_e      st_q, st_d;
  logic [W-1:0] ma_q, mb_q, acc_q;
  logic [W-1:0] blo_ext, prod_lo;
  logic [HALF-1:0] prod_hi;
  logic         ld_ops, ld_acc;

  always_comb begin
    st_d = st_q;
    case (st_q)
      MS_IDLE: if (start) st_d = MS_LO;
      MS_LO:   st_d = MS_HI;
      MS_HI:   st_d = MS_IDLE;
      default: st_d = MS_IDLE;
    endcase
  end

  assign ld_ops  = start && (st_q == MS_IDLE);
  assign ld_acc  = (st_q == MS_LO);
  assign blo_ext = {{HALF{1'b0}}, mb_q[HALF-1:0]};
  assign prod_lo = ma_q * blo_ext;
  assign prod_hi = ma_q[HALF-1:0] * mb_q[W-1:HALF];
  assign result  = acc_q + {prod_hi, {HALF{1'b0}}};
  assign busy    = (st_q != MS_IDLE);
  assign wb      = (st_q == MS_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= MS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma_q <= '0;
      mb_q <= '0;
    end else if (ld_ops) begin
      ma_q <= opnd_a;
      mb_q <= opnd_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (ld_acc) acc_q <= prod_lo;
  end

  // R6
  mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ops |=> busy ##1 wb ##1 !busy);

  // R6
  mul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_acc) |=> $stable(ma_q) && $stable(mb_q));

endmodule

// File: rtl/estk_core.sv
module estk_core
  import estk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  output logic [W-1:0] top_q,
  output logic [W-1:0] pop_q,
  output logic         busy,
  output logic         done
);

  logic         rst_m_q, rst_s_q;
  logic         accept;
  logic         push_en, pop_en, alu_en, mul_start, fold_en;
  logic         mul_busy, mul_wb;
  logic [W-1:0] a_q, b_q, c_q;
  logic [W-1:0] sum, diff, shres, mulres, fold_val;
  logic         done_d;
  stk_op_e      op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign op        = stk_op_e'(cmd_op);
  assign accept    = cmd_valid && !mul_busy;
  assign push_en   = accept && (op == OP_PUSH);
  assign pop_en    = accept && (op == OP_POP);
  assign alu_en    = accept && (op == OP_ADD || op == OP_SUB ||
                                op == OP_SHL || op == OP_SHR);
  assign mul_start = accept && (op == OP_MUL);
  assign fold_en   = alu_en || mul_wb;

  assign sum  = b_q + a_q;
  assign diff = b_q - a_q;

  estk_shift #(.W(W)) u_shift (
    .go_left (op == OP_SHL),
    .val     (b_q),
    .amt     (a_q),
    .res     (shres)
  );

  estk_mul #(.W(W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .start  (mul_start),
    .opnd_a (a_q),
    .opnd_b (b_q),
    .busy   (mul_busy),
    .wb     (mul_wb),
    .result (mulres)
  );

  always_comb begin
    if (mul_wb) fold_val = mulres;
    else begin
      case (op)
        OP_ADD:  fold_val = sum;
        OP_SUB:  fold_val = diff;
        default: fold_val = shres;
      endcase
    end
  end

  estk_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .push_en  (push_en),
    .pop_en   (pop_en),
    .fold_en  (fold_en),
    .push_val (cmd_data),
    .fold_val (fold_val),
    .a_q      (a_q),
    .b_q      (b_q),
    .c_q      (c_q)
  );

  assign done_d = push_en || pop_en || fold_en;

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) done <= 1'b0;
    else          done <= done_d;
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q)    pop_q <= '0;
    else if (pop_en) pop_q <= a_q;
  end

  assign top_q = a_q;
  assign busy  = mul_busy;

  // R3
  pop_out_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    pop_en |=> (pop_q == $past(a_q)));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (busy && !mul_wb) |=> $stable(top_q) && $stable(pop_q));

  // R8
  shift_far_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (accept && (op == OP_SHL || op == OP_SHR) && (a_q >= W)) |=> (top_q == '0));

  // R9
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (accept && op == OP_NOP) |=> !done && $stable(top_q));

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    busy |-> !done);

endmodule

// File: tb/estk_core_test.sv
module estk_core_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_data;
  logic [31:0] top_q, pop_q;
  logic        busy, done;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] top;
    bit          top_ok;
    bit          is_pop;
    logic [31:0] popv;
    bit          pop_ok;
    string       req;
  } exp_t;

  exp_t exq[$];

  logic [31:0] mA, mB, mC;
  bit          kA, kB, kC;

  always #5 clk = ~clk;

  estk_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .top_q     (top_q),
    .pop_q     (pop_q),
    .busy      (busy),
    .done      (done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // model update and expected-item generation
  task automatic model(input logic [2:0] op, input logic [31:0] d, input string req);
    exp_t e;
    logic [31:0] r;
    e.is_pop = 0; e.popv = '0; e.pop_ok = 0; e.req = req;
    case (op)
      3'd1: begin mC = mB; kC = kB; mB = mA; kB = kA; mA = d; kA = 1; end
      3'd2: begin
        e.is_pop = 1; e.popv = mA; e.pop_ok = kA;
        mA = mB; kA = kB; mB = mC; kB = kC; kC = 0;
      end
      default: begin
        case (op)
          3'd3: r = mB + mA;
          3'd4: r = mB - mA;
          3'd5: r = 32'(64'(mB) * 64'(mA));
          3'd6: r = (mA >= 32) ? 32'd0 : (mB << mA[4:0]);
          default: r = (mA >= 32) ? 32'd0 : (mB >> mA[4:0]);
        endcase
        kA = kA && kB; mA = r; mB = mC; kB = kC; kC = 0;
      end
    endcase
    e.top = mA; e.top_ok = kA;
    exq.push_back(e);
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] d, input string req);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = d;
    if (op != 3'd0) model(op, d, req);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // R6 / R7: multiply with optional command injected during busy
  task automatic do_mul(input bit inject);
    issue(3'd5, 32'd0, "R6");
    chk(busy == 1 && done == 0, "R6 busy after accept", {30'd0, busy, done}, 32'h2);
    if (inject) begin
      cmd_valid = 1; cmd_op = 3'd1; cmd_data = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 1 && done == 0, "R6 busy second cycle", {30'd0, busy, done}, 32'h2);
    @(negedge clk);
    chk(busy == 0 && done == 1, "R6 result third cycle", {30'd0, busy, done}, 32'h1);
  endtask

  // monitor: compare on every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exq.size() == 0) begin
        chk(0, "R10 unexpected done", {31'd0, done}, 32'd0);
      end else begin
        exp_t e;
        e = exq.pop_front();
        if (e.top_ok) chk(top_q == e.top, {e.req, " top"}, top_q, e.top);
        if (e.is_pop && e.pop_ok) chk(pop_q == e.popv, {e.req, " popped"}, pop_q, e.popv);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cmd_valid = 0; cmd_op = 0; cmd_data = 0;
    mA = 0; mB = 0; mC = 0; kA = 1; kB = 1; kC = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(top_q == 0 && pop_q == 0, "R1 outputs in reset", top_q | pop_q, 32'd0);
    chk(busy == 0 && done == 0, "R1 flags in reset", {30'd0, busy, done}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(top_q == 0 && busy == 0 && done == 0, "R1 after release", top_q, 32'd0);

    // R1: B and C zero, brought out by popping
    issue(3'd2, 0, "R1 R3");
    issue(3'd2, 0, "R1 R3");
    issue(3'd2, 0, "R1 R3");

    // R2 push order, R3 pop order
    issue(3'd1, 32'h11, "R2");
    issue(3'd1, 32'h22, "R2");
    issue(3'd1, 32'h33, "R2");
    issue(3'd2, 0, "R3");
    issue(3'd2, 0, "R3");
    issue(3'd2, 0, "R3");

    // R9 nop
    issue(3'd1, 32'hA5A5_0001, "R2");
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd0; cmd_data = 32'h5555_5555;
    @(negedge clk);
    cmd_valid = 0;
    chk(done == 0 && top_q == 32'hA5A5_0001, "R9 nop", top_q, 32'hA5A5_0001);

    // R4 add with wrap
    issue(3'd1, 32'hFFFF_FFFF, "R2");
    issue(3'd1, 32'd2, "R2");
    issue(3'd3, 0, "R4");
    issue(3'd1, 32'd1000, "R2");
    issue(3'd1, 32'd234, "R2");
    issue(3'd3, 0, "R4");

    // R5 subtract B - A with wrap
    issue(3'd1, 32'd5, "R2");
    issue(3'd1, 32'd7, "R2");
    issue(3'd4, 0, "R5");
    issue(3'd1, 32'd9, "R2");
    issue(3'd4, 0, "R5");

    // R6 multiply
    issue(3'd1, 32'h1234_5678, "R2");
    issue(3'd1, 32'h9ABC_DEF1, "R2");
    do_mul(0);
    issue(3'd1, 32'hFFFF_FFFF, "R2");
    issue(3'd1, 32'hFFFF_FFFF, "R2");
    do_mul(0);

    // R7 command during busy is dropped
    issue(3'd1, 32'h0000_0777, "R2");
    issue(3'd1, 32'd3, "R2");
    issue(3'd1, 32'h0001_0003, "R2");
    do_mul(1);
    issue(3'd2, 0, "R7");
    issue(3'd2, 0, "R7");

    // R8 shifts
    issue(3'd1, 32'h8000_0001, "R2");
    issue(3'd1, 32'd4, "R2");
    issue(3'd6, 0, "R8");
    issue(3'd1, 32'h8000_0000, "R2");
    issue(3'd1, 32'd31, "R2");
    issue(3'd7, 0, "R8");
    issue(3'd1, 32'hFFFF_FFFF, "R2");
    issue(3'd1, 32'd32, "R2");
    issue(3'd6, 0, "R8");
    issue(3'd1, 32'hFFFF_FFFF, "R2");
    issue(3'd1, 32'hFFFF_FFFF, "R2");
    issue(3'd7, 0, "R8");
    issue(3'd1, 32'hCAFE_F00D, "R2");
    issue(3'd1, 32'd0, "R2");
    issue(3'd7, 0, "R8");

    repeat (4) @(negedge clk);
    chk(exq.size() == 0, "R10 all commands done", exq.size(), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule